// File: doc/BRIEF.md
# Temperature Fault and Limit Status Aggregator

This block gathers the condition flags of a multi-channel temperature monitor and turns them into readable status and an interrupt-style alert line. Each cycle it accepts one flag per channel for each of three limit checks (high limit, low limit, thermal-shutdown limit) and one flag per remote channel for a broken or open sensing diode. Every flag is latched into a per-kind status register and stays set after the condition disappears. Only a read of that register clears it.

A summary register reduces each per-kind register to one bit. A per-channel mask register decides which channels may pull the active-low alert output. Channel 0 is the on-die sensor, so it can never report a diode fault. The comparison logic upstream drives the flag inputs, and a host reaches the registers through a simple strobe-based read/write port.

Register map (byte-wide, `reg_addr_i`):

| Address | Contents | Access |
|---|---|---|
| 0 | summary: bit 3 HIGH, bit 2 LOW, bit 1 THERM, bit 0 OPEN, upper bits 0 | read, no clear |
| 1 | high-limit flags, bit c = channel c | read clears |
| 2 | low-limit flags | read clears |
| 3 | thermal-limit flags | read clears |
| 4 | diode-fault flags, bit 0 always 0 | read clears |
| 5 | channel mask, bit c = 1 excludes channel c from the alert | read/write |

Top module: `tsa_status_agg`

## Requirements
- R1: After reset, all four flag registers, the summary register and the mask register read 0, and `alert_n_o` is 1.
- R2: A high-limit flag on channel c sets bit c of address 1 at the next clock edge. The bit stays set after the input returns low.
- R3: A low-limit flag on channel c sets bit c of address 2, and a thermal-limit flag on channel c sets bit c of address 3. Both are sticky in the same way as R2.
- R4: Several channels flagged in the same cycle set all of the corresponding bits together.
- R5: A diode-fault flag on channel c ≥ 1 sets bit c of address 4. Bit 0 of address 4 always reads 0, whatever `open_evt_i[0]` does.
- R6: Address 0 reads bit 3 = OR of address 1, bit 2 = OR of address 2, bit 1 = OR of address 3, bit 0 = OR of address 4. All higher bits read 0.
- R7: A write to address 5 stores `reg_wdata_i[NCH-1:0]` as the mask. Bits above NCH-1 read back as 0.
- R8: `alert_n_o` is 0 exactly when some channel whose mask bit is 0 has a set bit in any of addresses 1 to 4. It follows the flag registers with no extra delay.
- R9: Reading address 1, 2, 3 or 4 (`reg_rd_i` high at a clock edge) returns the current value and clears that register at that edge. Reading address 0 or 5 clears nothing.
- R10: A flag that arrives in the same cycle as a clearing read of its register stays set after that edge.
- R11: Writes to addresses 0 to 4 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_evt_i | input | NCH | High-limit exceedance flag per channel |
| lo_evt_i | input | NCH | Low-limit exceedance flag per channel |
| therm_evt_i | input | NCH | Thermal-limit exceedance flag per channel |
| open_evt_i | input | NCH | Diode open/fault flag per channel (bit 0 ignored) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears flag registers) |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational from address |
| alert_n_o | output | 1 | Active-low alert |

## Verification
A clearing read and a new flag on the same register can fall in the same clock edge. If the design let the clear win, the flag would be lost. The bench holds a high-limit flag on channel 1 while it strobes a read of address 1. It expects the read data to show the old contents and a following read to return the channel-1 bit (R10). A separate sweep over every mask value, every channel and every flag kind checks the alert level, the summary bit and the clear against values the bench works out from the mask and channel numbers.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  // register addresses
  localparam int unsigned ADDR_SUM  = 0;
  localparam int unsigned ADDR_HIGH = 1;  // flag kinds follow at ADDR_HIGH + kind
  localparam int unsigned ADDR_MASK = 5;
  // flag kinds, also the order of the flag banks
  localparam int unsigned K_HIGH  = 0;
  localparam int unsigned K_LOW   = 1;
  localparam int unsigned K_THERM = 2;
  localparam int unsigned K_OPEN  = 3;
  localparam int unsigned NKIND   = 4;
  // summary bit positions
  localparam int unsigned SB_OPEN  = 0;
  localparam int unsigned SB_THERM = 1;
  localparam int unsigned SB_LOW   = 2;
  localparam int unsigned SB_HIGH  = 3;
endpackage

// File: rtl/tsa_sticky_bank.sv
module tsa_sticky_bank #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  // set has priority over the clear, so a flag arriving during the read survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= ((clr_i ? '0 : q_r) | set_i) & LIVE;
  end

  assign q_o = q_r;
endmodule

// File: rtl/tsa_alert_gen.sv
module tsa_alert_gen #(
  parameter int unsigned NCH = 3,
  parameter int unsigned NK  = 4
) (
  input  logic [NK-1:0][NCH-1:0] flags_i,
  input  logic [NCH-1:0]         mask_i,
  output logic                   alert_n_o
);
  logic [NCH-1:0] per_ch;

  always_comb begin
    per_ch = '0;
    for (int k = 0; k < NK; k++) per_ch = per_ch | flags_i[k];
  end

  assign alert_n_o = ~|(per_ch & ~mask_i);
endmodule

// File: rtl/tsa_status_agg.sv
module tsa_status_agg
  import tsa_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hi_evt_i,
  input  logic [NCH-1:0] lo_evt_i,
  input  logic [NCH-1:0] therm_evt_i,
  input  logic [NCH-1:0] open_evt_i,
  input  logic           reg_wr_i,
  input  logic           reg_rd_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           alert_n_o
);
  localparam logic [NCH-1:0] ALL_CH   = '1;
  localparam logic [NCH-1:0] FLT_LIVE = {ALL_CH[NCH-1:1], 1'b0};

  logic [NKIND-1:0][NCH-1:0] evt;
  logic [NKIND-1:0][NCH-1:0] flags;
  logic [NCH-1:0]            mask_q;
  logic [DW-1:0]             summary;
  logic                      unused_wdata;

  assign evt[K_HIGH]  = hi_evt_i;
  assign evt[K_LOW]   = lo_evt_i;
  assign evt[K_THERM] = therm_evt_i;
  assign evt[K_OPEN]  = open_evt_i;

  for (genvar k = 0; k < NKIND; k++) begin : g_bank
    localparam logic [NCH-1:0] LIVE = (k == K_OPEN) ? FLT_LIVE : ALL_CH;
    logic clr;
    assign clr = reg_rd_i && (reg_addr_i == AW'(ADDR_HIGH + k));
    tsa_sticky_bank #(.W(NCH), .LIVE(LIVE)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt[k]),
      .clr_i (clr),
      .q_o   (flags[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          mask_q <= '0;
    else if (reg_wr_i && reg_addr_i == AW'(ADDR_MASK))   mask_q <= reg_wdata_i[NCH-1:0];
  end
  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    summary           = '0;
    summary[SB_HIGH]  = |flags[K_HIGH];
    summary[SB_LOW]   = |flags[K_LOW];
    summary[SB_THERM] = |flags[K_THERM];
    summary[SB_OPEN]  = |flags[K_OPEN];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(ADDR_SUM))
      reg_rdata_o = summary;
    else if (reg_addr_i == AW'(ADDR_MASK))
      reg_rdata_o[NCH-1:0] = mask_q;
    else
      for (int k = 0; k < NKIND; k++)
        if (reg_addr_i == AW'(ADDR_HIGH + k)) reg_rdata_o[NCH-1:0] = flags[k];
  end

  tsa_alert_gen #(.NCH(NCH), .NK(NKIND)) alert_i (
    .flags_i   (flags),
    .mask_i    (mask_q),
    .alert_n_o (alert_n_o)
  );
endmodule

// File: rtl/tsa_status_agg_chk.sv
module tsa_status_agg_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       hi_evt,
  input logic                 rd,
  input logic                 wr,
  input logic [AW-1:0]        addr,
  input logic [3:0][NCH-1:0]  flags,
  input logic [NCH-1:0]       mask,
  input logic                 alert_n
);
  // R8
  alert_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_n == ~|((flags[0] | flags[1] | flags[2] | flags[3]) & ~mask));

  // R10
  hi_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_evt != '0) |=> ((flags[0] & $past(hi_evt)) == $past(hi_evt)));

  // R9
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == AW'(1) && hi_evt == '0) |=> (flags[0] == '0));

  // R5
  fault_local_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3][0] == 1'b0);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == AW'(5)) |=> $stable(mask));
endmodule

bind tsa_status_agg tsa_status_agg_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .hi_evt  (hi_evt_i),
  .rd      (reg_rd_i),
  .wr      (reg_wr_i),
  .addr    (reg_addr_i),
  .flags   (flags),
  .mask    (mask_q),
  .alert_n (alert_n_o)
);

// File: tb/tsa_status_agg_tb_top.sv
module tsa_status_agg_tb_top;
  localparam int NCH = 3;
  localparam int DW  = 8;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] hi_evt = '0, lo_evt = '0, th_evt = '0, op_evt = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic alert_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tsa_status_agg #(.NCH(NCH), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hi_evt_i(hi_evt), .lo_evt_i(lo_evt), .therm_evt_i(th_evt), .open_evt_i(op_evt),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .alert_n_o(alert_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // read: data sampled before the edge, clear (if any) happens at that edge
  task automatic rd_reg(input int a, output int v);
    @(negedge clk);
    reg_addr = AW'(a);
    reg_rd = 1'b1;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_addr = AW'(a);
    reg_wdata = DW'(d);
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int kind, input int ch_bits);
    @(negedge clk);
    case (kind)
      0: hi_evt = NCH'(ch_bits);
      1: lo_evt = NCH'(ch_bits);
      2: th_evt = NCH'(ch_bits);
      default: op_evt = NCH'(ch_bits);
    endcase
    @(negedge clk);
    hi_evt = '0; lo_evt = '0; th_evt = '0; op_evt = '0;
    #1;
  endtask

  task automatic clear_all();
    int v;
    for (int a = 1; a <= 4; a++) rd_reg(a, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 alert", int'(alert_n), 1);
    for (int a = 0; a <= 5; a++) begin
      rd_reg(a, v);
      check("R1 reg", v, 0);
    end

    // R7 mask write, upper bits dropped
    wr_reg(5, 8'hFF);
    rd_reg(5, v);
    check("R7 mask", v, 7);
    // R11 writes to status addresses ignored
    pulse(0, 3'b010);
    for (int a = 0; a <= 4; a++) wr_reg(a, 8'hFF);
    rd_reg(5, v);  check("R11 mask kept", v, 7);
    rd_reg(4, v);  check("R11 fault", v, 0);
    rd_reg(0, v);  check("R11 summary", v, 8);
    rd_reg(1, v);  check("R11 high kept", v, 2);

    // R4 simultaneous channels
    wr_reg(5, 0);
    pulse(1, 3'b111);
    rd_reg(2, v);  check("R4 low all", v, 7);
    pulse(3, 3'b111);
    rd_reg(4, v);  check("R4 R5 fault all", v, 6);

    // sweep: kind x channel x mask
    for (int kind = 0; kind < 4; kind++)
      for (int ch = 0; ch < NCH; ch++)
        for (int m = 0; m < (1 << NCH); m++) begin
          bit set_exp;
          clear_all();
          wr_reg(5, m);
          pulse(kind, 1 << ch);
          repeat (2) @(negedge clk);   // input low again: still sticky
          #1;
          set_exp = !(kind == 3 && ch == 0);
          // R8 alert level
          check("R8 alert", int'(alert_n), (set_exp && !m[ch]) ? 0 : 1);
          // R6 summary
          rd_reg(0, v);
          check("R6 summary", v, set_exp ? (1 << (3 - kind)) : 0);
          // R2 R3 R5 sticky flag
          rd_reg(1 + kind, v);
          check(kind == 0 ? "R2 flag" : (kind == 3 ? "R5 flag" : "R3 flag"),
                v, set_exp ? (1 << ch) : 0);
          // R9 clear by read
          rd_reg(1 + kind, v);
          check("R9 cleared", v, 0);
          #1 check("R9 alert off", int'(alert_n), 1);
        end

    // R9 summary and mask reads do not clear
    wr_reg(5, 0);
    pulse(2, 3'b100);
    rd_reg(0, v); rd_reg(5, v);
    rd_reg(3, v);  check("R9 no clear by addr0/5", v, 4);

    // R10 flag arrives in the clearing cycle
    pulse(0, 3'b001);
    @(negedge clk);
    reg_addr = AW'(1);
    reg_rd = 1'b1;
    hi_evt = 3'b010;
    #1 v = int'(reg_rdata);
    check("R10 old data", v, 1);
    @(negedge clk);
    reg_rd = 1'b0;
    hi_evt = '0;
    rd_reg(1, v);  check("R10 survives", v, 2);

    finish_up();
  end
endmodule